// File: doc/BRIEF.md
# Manchester Report Frame Serialiser

This block turns one report (a device address, a status byte and an event count) into a single serial frame on one output line. A one-cycle start strobe captures the report fields and arms the block. The frame is then sent at a pace set by an external half-bit enable. It is a long run of preamble bytes, then a start byte, the address, the status byte, the count and a 16-bit checksum. Each bit goes out as two half-bit symbols, so the receiver can recover the clock from the line itself.

The checksum is a reflected CRC-16 that starts from zero. It is computed bit by bit as the message bytes leave the block, so no second pass over the frame is needed. While a frame is in flight the block reports busy, and a new start strobe in that time is dropped. When the frame ends, the line returns to its idle low level and a one-cycle done pulse is raised.

Top module: `frame_tx`

## Requirements
- R1: Reset drives `line`, `busy` and `done` low.
- R2: A `start` pulse seen while `busy` is low is accepted, and `busy` is high from the next clock edge. `line` stays low until the first `halfTick` after that.
- R3: The frame consists of 65 bytes of 0x7E, then 0xAA, then the four address bytes with the most significant first, then the status byte, then the count high byte, then the count low byte, then the CRC low byte, then the CRC high byte. That is 75 bytes in total.
- R4: Every byte is sent least significant bit first.
- R5: Every bit takes two consecutive half periods. In the first half, `line` carries the inverted bit. In the second half, it carries the bit itself. `line` changes only on a clock edge where `halfTick` is high. The h-th accepted `halfTick` of a frame (h = 1 to 1200) presents half symbol h.
- R6: The CRC starts at 0x0000. For each message bit b, taken LSB first, let f = crc[0] XOR b. The CRC then shifts right with a 0 entering bit 15, and it is XORed with 0xA001 when f is 1. The CRC covers the 8 bytes made up of the start byte, the address, the status and the count. The preamble is not included.
- R7: The 1201st `halfTick` of a frame returns `line` low and drops `busy`. On that same edge, `done` is raised for exactly one cycle.
- R8: A `start` pulse while `busy` is high is ignored. The frame in flight is unchanged, and no second frame follows it.
- R9: The address, status and count are sampled only when `start` is accepted. Changing them during a frame has no effect on that frame.
- R10: `halfTick` pulses while idle leave `line` low and `busy` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to send a frame |
| halfTick | input | 1 | Half-bit pacing enable, one cycle per half symbol |
| addrIn | input | 32 | Device address |
| statusIn | input | 8 | Input status byte |
| countIn | input | 16 | Event count |
| line | output | 1 | Manchester-coded serial output, idle low |
| busy | output | 1 | High from the accepted start to the end of the frame |
| done | output | 1 | One-cycle pulse when the frame ends |

## Verification
The bench drives each `halfTick` for one cycle. It compares `line` at the falling edge that follows, because the line register updates on the same rising edge that samples the tick. `busy` is checked at the first falling edge after the accepted start, since it is a single register away from the strobe. `done`, the fall of `busy` and the return of `line` to low are all checked at the falling edge after the 1201st tick, and the bench then confirms one edge later that `done` has dropped. Disturbance tests apply a start strobe or new field values in the middle of a frame. For those tests, the bench counts mismatches over the rest of that frame and then checks for a silent line once the frame has ended.

// File: rtl/frame_tx_pkg.sv
`timescale 1ns/1ps
package frame_tx_pkg;
  localparam int IDX_W = 8;

  typedef struct packed {
    logic             capture;
    logic             loadByte;
    logic             nextBit;
    logic             showFirst;
    logic             showSecond;
    logic             endFrame;
    logic [IDX_W-1:0] byteSel;
  } txStrobes_t;
endpackage

// File: rtl/frame_tx_ctrl.sv
`timescale 1ns/1ps
module frame_tx_ctrl
  import frame_tx_pkg::*;
#(
  parameter int TOTAL_BYTES = 75
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       halfTick,
  output txStrobes_t strb,
  output logic       busy,
  output logic       done
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL_BYTES - 1);
  localparam logic [IDX_W-1:0] ONE_IDX  = IDX_W'(1);

  typedef enum logic [1:0] {S_IDLE, S_ARMED, S_SEND} ctrlState_t;

  ctrlState_t       stateQ, stateD;
  logic [IDX_W-1:0] byteIdxQ;
  logic [2:0]       bitIdxQ;
  logic             secondHalfQ;

  always_comb begin
    strb         = '0;
    strb.byteSel = byteIdxQ;
    stateD       = stateQ;
    unique case (stateQ)
      S_IDLE: begin
        strb.capture = start;
        if (start) stateD = S_ARMED;
      end
      S_ARMED: begin
        if (halfTick) begin
          strb.loadByte  = 1'b1;
          strb.byteSel   = '0;
          strb.showFirst = 1'b1;
          stateD         = S_SEND;
        end
      end
      S_SEND: begin
        if (halfTick) begin
          if (!secondHalfQ) begin
            strb.showSecond = 1'b1;
          end else if (bitIdxQ != 3'd7) begin
            strb.nextBit   = 1'b1;
            strb.showFirst = 1'b1;
          end else if (byteIdxQ == LAST_IDX) begin
            strb.endFrame = 1'b1;
            stateD        = S_IDLE;
          end else begin
            strb.loadByte  = 1'b1;
            strb.byteSel   = byteIdxQ + ONE_IDX;
            strb.showFirst = 1'b1;
          end
        end
      end
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ      <= S_IDLE;
      byteIdxQ    <= '0;
      bitIdxQ     <= '0;
      secondHalfQ <= 1'b0;
      done        <= 1'b0;
    end else begin
      stateQ <= stateD;
      done   <= strb.endFrame;
      if (strb.loadByte) begin
        byteIdxQ <= strb.byteSel;
        bitIdxQ  <= '0;
      end else if (strb.nextBit) begin
        bitIdxQ <= bitIdxQ + 3'd1;
      end
      if (strb.showFirst) secondHalfQ <= 1'b0;
      else if (strb.showSecond) secondHalfQ <= 1'b1;
    end
  end

  assign busy = (stateQ != S_IDLE);
endmodule

// File: rtl/frame_tx_dp.sv
`timescale 1ns/1ps
module frame_tx_dp
  import frame_tx_pkg::*;
#(
  parameter int          PRE_LEN    = 65,
  parameter logic [7:0]  PRE_BYTE   = 8'h7E,
  parameter logic [7:0]  SOF_BYTE   = 8'hAA,
  parameter int          ADDR_BYTES = 4,
  parameter int          CNT_BYTES  = 2,
  parameter logic [15:0] CRC_POLY   = 16'hA001
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  txStrobes_t              strb,
  input  logic [8*ADDR_BYTES-1:0] addrIn,
  input  logic [7:0]              statusIn,
  input  logic [8*CNT_BYTES-1:0]  countIn,
  output logic                    line
);
  localparam int MSG_BYTES = 1 + ADDR_BYTES + 1 + CNT_BYTES;
  localparam int SOF_IDX   = PRE_LEN;
  localparam int CRC_IDX   = PRE_LEN + MSG_BYTES;

  logic [8*ADDR_BYTES-1:0] addrQ;
  logic [7:0]              statusQ;
  logic [8*CNT_BYTES-1:0]  countQ;
  logic [7:0]              shiftQ;
  logic [15:0]             crcQ;
  logic                    inCrcQ;
  logic                    lineQ;

  logic [7:0] msgByte [MSG_BYTES];
  logic [7:0] pickByte;
  logic       pickInCrc;
  logic       newBit;

  assign msgByte[0] = SOF_BYTE;
  for (genvar a = 0; a < ADDR_BYTES; a++) begin : g_addrLane
    assign msgByte[1 + a] = addrQ[8*(ADDR_BYTES-1-a) +: 8];
  end
  assign msgByte[1 + ADDR_BYTES] = statusQ;
  for (genvar c = 0; c < CNT_BYTES; c++) begin : g_cntLane
    assign msgByte[2 + ADDR_BYTES + c] = countQ[8*(CNT_BYTES-1-c) +: 8];
  end

  function automatic logic [15:0] crcStep(input logic [15:0] cur, input logic b);
    logic [15:0] nxt;
    nxt = {1'b0, cur[15:1]};
    if (cur[0] ^ b) nxt = nxt ^ CRC_POLY;
    return nxt;
  endfunction

  always_comb begin
    pickByte  = PRE_BYTE;
    pickInCrc = 1'b0;
    for (int k = 0; k < MSG_BYTES; k++) begin
      if (int'(strb.byteSel) == SOF_IDX + k) begin
        pickByte  = msgByte[k];
        pickInCrc = 1'b1;
      end
    end
    if (int'(strb.byteSel) == CRC_IDX)     pickByte = crcQ[7:0];
    if (int'(strb.byteSel) == CRC_IDX + 1) pickByte = crcQ[15:8];
  end

  assign newBit = strb.loadByte ? pickByte[0] : shiftQ[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      statusQ <= '0;
      countQ  <= '0;
      shiftQ  <= '0;
      crcQ    <= '0;
      inCrcQ  <= 1'b0;
      lineQ   <= 1'b0;
    end else begin
      if (strb.capture) begin
        addrQ   <= addrIn;
        statusQ <= statusIn;
        countQ  <= countIn;
        crcQ    <= '0;
        inCrcQ  <= 1'b0;
      end
      if (strb.loadByte) begin
        shiftQ <= pickByte;
        inCrcQ <= pickInCrc;
        if (pickInCrc) crcQ <= crcStep(crcQ, pickByte[0]);
      end else if (strb.nextBit) begin
        shiftQ <= {1'b0, shiftQ[7:1]};
        if (inCrcQ) crcQ <= crcStep(crcQ, shiftQ[1]);
      end
      if (strb.showFirst)       lineQ <= ~newBit;
      else if (strb.showSecond) lineQ <= shiftQ[0];
      else if (strb.endFrame)   lineQ <= 1'b0;
    end
  end

  assign line = lineQ;
endmodule

// File: rtl/frame_tx.sv
`timescale 1ns/1ps
module frame_tx
  import frame_tx_pkg::*;
#(
  parameter int          PRE_LEN    = 65,
  parameter logic [7:0]  PRE_BYTE   = 8'h7E,
  parameter logic [7:0]  SOF_BYTE   = 8'hAA,
  parameter int          ADDR_BYTES = 4,
  parameter int          CNT_BYTES  = 2,
  parameter logic [15:0] CRC_POLY   = 16'hA001
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic                    halfTick,
  input  logic [8*ADDR_BYTES-1:0] addrIn,
  input  logic [7:0]              statusIn,
  input  logic [8*CNT_BYTES-1:0]  countIn,
  output logic                    line,
  output logic                    busy,
  output logic                    done
);
  localparam int TOTAL_BYTES = PRE_LEN + 1 + ADDR_BYTES + 1 + CNT_BYTES + 2;

  txStrobes_t strb;

  frame_tx_ctrl #(.TOTAL_BYTES(TOTAL_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .halfTick(halfTick),
    .strb(strb), .busy(busy), .done(done)
  );

  frame_tx_dp #(
    .PRE_LEN(PRE_LEN), .PRE_BYTE(PRE_BYTE), .SOF_BYTE(SOF_BYTE),
    .ADDR_BYTES(ADDR_BYTES), .CNT_BYTES(CNT_BYTES), .CRC_POLY(CRC_POLY)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .addrIn(addrIn),
    .statusIn(statusIn), .countIn(countIn), .line(line)
  );
endmodule

// File: rtl/frame_tx_chk.sv
`timescale 1ns/1ps
module frame_tx_chk (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic halfTick,
  input logic line,
  input logic busy,
  input logic done
);
  // R7: the done pulse coincides with busy falling
  a_r7_done_ends_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));
  // R7: done lasts one cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R2: an idle start is accepted
  a_r2_accept: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);
  // R8: only a tick can end a frame; start cannot disturb busy
  a_r8_busy_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !halfTick) |=> busy);
  // R10: idle line is low
  a_r10_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !line);
  // R5: line moves only after a tick edge
  a_r5_tick_paced: assert property (@(posedge clk) disable iff (!rstN)
    !$past(halfTick) |-> $stable(line));
endmodule

bind frame_tx frame_tx_chk u_chk (
  .clk(clk), .rstN(rstN), .start(start), .halfTick(halfTick),
  .line(line), .busy(busy), .done(done)
);

// File: tb/sim_frame_tx.sv
`timescale 1ns/1ps
module sim_frame_tx;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        halfTick = 1'b0;
  logic [31:0] addrIn = '0;
  logic [7:0]  statusIn = '0;
  logic [15:0] countIn = '0;
  logic        line, busy, done;

  int vecCnt = 0;
  int errCnt = 0;
  int cycles = 0;
  int frameErr;

  always #2.5 clk = ~clk;

  frame_tx u0 (
    .clk(clk), .rstN(rstN), .start(start), .halfTick(halfTick),
    .addrIn(addrIn), .statusIn(statusIn), .countIn(countIn),
    .line(line), .busy(busy), .done(done)
  );

  // stimulus: {addr, status, count}; expected frame computed below
  localparam logic [55:0] VECS [5] = '{
    {32'h0000_0000, 8'h00, 16'h0000},
    {32'hFFFF_FFFF, 8'hFF, 16'hFFFF},
    {32'h1234_5678, 8'h5A, 16'h03F2},
    {32'h8000_0001, 8'h00, 16'h8000},
    {32'hDEAD_BEEF, 8'hC3, 16'h0001}
  };

  logic [7:0] expBytes [75];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vecCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] refCrc(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {8'h00, b};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ 16'hA001) : (r >> 1);
    return r;
  endfunction

  task automatic buildFrame(input logic [31:0] a, input logic [7:0] s, input logic [15:0] n);
    logic [15:0] crc;
    for (int i = 0; i < 65; i++) expBytes[i] = 8'h7E;
    expBytes[65] = 8'hAA;
    expBytes[66] = a[31:24]; expBytes[67] = a[23:16];
    expBytes[68] = a[15:8];  expBytes[69] = a[7:0];
    expBytes[70] = s;
    expBytes[71] = n[15:8];  expBytes[72] = n[7:0];
    crc = 16'h0000;
    for (int i = 65; i < 73; i++) crc = refCrc(crc, expBytes[i]);
    expBytes[73] = crc[7:0];
    expBytes[74] = crc[15:8];
  endtask

  task automatic pulseTick();
    repeat (2) @(negedge clk);
    halfTick = 1'b1;
    @(negedge clk);
    halfTick = 1'b0;
  endtask

  // mode 0: clean, 1: new start mid-frame (R8), 2: fields change mid-frame (R9)
  task automatic sendFrame(input logic [55:0] v, input int mode);
    logic expLine;
    int   bitNo;
    string tag;
    buildFrame(v[55:24], v[23:16], v[15:0]);
    frameErr = 0;
    @(negedge clk);
    {addrIn, statusIn, countIn} = v;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", 32'(busy), 1);
    repeat (3) @(negedge clk);
    chk(line == 1'b0, "R2 line before first tick", 32'(line), 0);
    for (int h = 0; h < 1200; h++) begin
      if (h == 300 && mode == 1) begin
        {addrIn, statusIn, countIn} = ~v;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
      if (h == 300 && mode == 2) {addrIn, statusIn, countIn} = ~v;
      pulseTick();
      bitNo   = h / 2;
      expLine = (h % 2 == 1) ? expBytes[bitNo/8][bitNo%8] : ~expBytes[bitNo/8][bitNo%8];
      if (bitNo / 8 < 66)      tag = "R3 preamble/start";
      else if (bitNo / 8 < 73) tag = "R4 message bits";
      else                     tag = "R6 crc bits";
      if (line !== expLine) frameErr++;
      chk(line === expLine, $sformatf("%s R5 half %0d", tag, h), 32'(line), 32'(expLine));
    end
    chk(busy == 1'b1, "R7 busy through last half", 32'(busy), 1);
    pulseTick();
    chk(done == 1'b1, "R7 done pulse", 32'(done), 1);
    chk(busy == 1'b0, "R7 busy drops", 32'(busy), 0);
    chk(line == 1'b0, "R7 line idle", 32'(line), 0);
    @(negedge clk);
    chk(done == 1'b0, "R7 done single cycle", 32'(done), 0);
    if (mode == 1) begin
      chk(frameErr == 0, "R8 frame intact after ignored start", 32'(frameErr), 0);
      for (int t = 0; t < 4; t++) begin
        pulseTick();
        chk(line == 1'b0 && busy == 1'b0, "R8 no second frame", {30'd0, busy, line}, 0);
      end
    end
    if (mode == 2) chk(frameErr == 0, "R9 fields sampled at start", 32'(frameErr), 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errCnt++;
      vecCnt++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(line == 1'b0, "R1 line reset", 32'(line), 0);
    chk(busy == 1'b0, "R1 busy reset", 32'(busy), 0);
    chk(done == 1'b0, "R1 done reset", 32'(done), 0);
    rstN = 1'b1;
    @(negedge clk);
    for (int t = 0; t < 3; t++) begin
      pulseTick();
      chk(line == 1'b0 && busy == 1'b0, "R10 idle tick", {30'd0, busy, line}, 0);
    end
    for (int i = 0; i < 5; i++) sendFrame(VECS[i], 0);
    sendFrame(VECS[2], 1);
    sendFrame(VECS[4], 2);
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end
endmodule